// File: doc/BRIEF.md
# Memory Type Range Resolver

This block answers one question for a memory controller or page walker: what cacheability type applies to a whole physical address range. A request gives an inclusive start and an exclusive end. The answer is an 8-bit type code, registered one cycle after the request. The answer comes from three register sources. The first is a table of 88 type bytes for the lowest megabyte, at three granularities. The second is a set of base/mask range pairs that may overlap. The third is a control word that holds the default type and two enable bits. An optional top-of-memory bound marks everything from 4 GiB up to that bound as write-back.

Two answers are not memory types. 0xFF means the resolver is not configured or is switched off. 0xFE means the requested range is only partly covered by some valid base/mask pair. Overlapping matches are merged by precedence. The pairs are visited from index 0 upward, and the first conclusive outcome ends the search, so the order of the pairs can change the answer.

All register contents are loaded through a single write port. The control word is the last register written in a load sequence, and writing it marks the resolver as loaded.

Top module: `memtype_resolver`

## Requirements
- R1: After reset, r_valid is 0 and r_type is 0xFF.
- R2: A query returns 0xFF while the control word has never been written, or while both of its enable bits (bit 10 and bit 11) are 0.
- R3: When the resolver is enabled and q_start is below 0x100000, the result is fixed-table entry k, whatever q_end or bit 10 is. Below 0x80000, k = q_start>>16. Below 0xC0000, k = 8+((q_start-0x80000)>>14). Otherwise k = 24+((q_start-0xC0000)>>12).
- R4: Outside the fixed region, when control bit 11 is 0, the result is the default type in control bits [7:0].
- R5: A base/mask pair takes part only when mask bit 11 is 1. Address bits [11:0] of base and mask never affect matching. The type of the pair is base bits [7:0].
- R6: A pair matches an address a when (a & mask) == (base & mask), with mask bits [11:0] taken as 0. If q_start and q_end-1 disagree on the match for a valid pair that is reached in the scan, the result is 0xFE.
- R7: Valid pairs are scanned from index 0 upward. If any two matching types include 0 (uncacheable), the result is 0. A 6 (write-back) and a 4 (write-through) merge to 4. Any other difference gives 0. A 0 or 0xFE outcome stops the scan.
- R8: If the scan did not stop early, the top bound is nonzero, q_start >= 0x1_0000_0000, and q_end-1 is below the bound, then the result is 6.
- R9: Otherwise the result is the merged type when at least one pair matched, and the default type when none matched.
- R10: q_end is exclusive: only q_end-1 is compared.
- R11: Write map, selected by wr_addr: 0x00..0x57 writes fixed entries from wr_data[7:0]. 0x60+2i writes base i and 0x61+2i writes mask i. 0x70 writes the control word. 0x71 writes the top bound. r_valid follows q_valid one cycle later, and r_type holds its value when q_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register select, see R11 |
| wr_data | input | ADDR_W | Write data |
| q_valid | input | 1 | Query strobe |
| q_start | input | ADDR_W | First byte address of the range |
| q_end | input | ADDR_W | Address one past the last byte of the range |
| r_valid | output | 1 | Result strobe, one cycle after q_valid |
| r_type | output | 8 | Resolved type, or 0xFF / 0xFE |

## Verification
Some properties are checked by assertions on every cycle:
- r_valid tracks q_valid with one cycle of delay.
- r_type holds its value on idle cycles.
- A disabled or unloaded resolver answers 0xFF.
- A query in the fixed region never answers 0xFE.
- The fixed index stays inside the table.

The bench scenarios cover the rest:
- the arithmetic of the fixed index;
- the precedence merge and its dependence on pair order;
- exact-fit versus one-byte-over ranges;
- the top-bound override and its boundaries.

These are compared against an arithmetic model in sweeps over every 4 KiB page of the first megabyte and over many generated range sets.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  localparam int FIX_ENTRIES = 88;
  localparam int FIX_IDX_W   = 7;
  localparam int PAGE_BITS   = 12;

  localparam logic [7:0] MT_UC    = 8'h00;
  localparam logic [7:0] MT_WT    = 8'h04;
  localparam logic [7:0] MT_WB    = 8'h06;
  localparam logic [7:0] MT_SPLIT = 8'hFE;
  localparam logic [7:0] MT_OFF   = 8'hFF;

  localparam logic [7:0] WA_VAR  = 8'h60;
  localparam logic [7:0] WA_CTRL = 8'h70;
  localparam logic [7:0] WA_TOP  = 8'h71;
endpackage

// File: rtl/mtr_fix_index.sv
module mtr_fix_index
  import mtr_pkg::*;
#(
  parameter int HI_W = 24
) (
  input  logic [HI_W-1:0]      pg,
  output logic                 in_low,
  output logic [FIX_IDX_W-1:0] idx
);
  // pg is the start address in 4 KiB pages; the first megabyte is 256 pages
  localparam logic [HI_W-1:0] PG_1M   = HI_W'(256);
  localparam logic [HI_W-1:0] PG_512K = HI_W'(128);
  localparam logic [HI_W-1:0] PG_768K = HI_W'(192);

  always_comb begin
    in_low = (pg < PG_1M);
    if (pg < PG_512K)      idx = FIX_IDX_W'(pg[6:4]);
    else if (pg < PG_768K) idx = FIX_IDX_W'(8)  + FIX_IDX_W'(pg[5:2]);
    else                   idx = FIX_IDX_W'(24) + FIX_IDX_W'(pg[5:0]);
  end

  always_comb begin
    if (in_low) assert_fix_idx_in_table_R3: assert (idx < FIX_IDX_W'(FIX_ENTRIES));
  end
endmodule

// File: rtl/mtr_var_scan.sv
module mtr_var_scan
  import mtr_pkg::*;
#(
  parameter int HI_W = 24,
  parameter int NVAR = 8
) (
  input  logic [HI_W-1:0] s_pg,
  input  logic [HI_W-1:0] e_pg,
  input  logic [HI_W-1:0] base_hi [NVAR],
  input  logic [7:0]      kind    [NVAR],
  input  logic [HI_W-1:0] mask_hi [NVAR],
  input  logic [NVAR-1:0] vld,
  output logic            stop,
  output logic [7:0]      stop_type,
  output logic            hit,
  output logic [7:0]      merged
);
  logic            s_in, e_in;
  logic [7:0]      cur;

  always_comb begin
    stop = 1'b0; stop_type = MT_UC; hit = 1'b0; merged = MT_UC;
    s_in = 1'b0; e_in = 1'b0; cur = MT_UC;
    for (int i = 0; i < NVAR; i++) begin
      if (!stop && vld[i]) begin
        s_in = ((s_pg & mask_hi[i]) == (base_hi[i] & mask_hi[i]));
        e_in = ((e_pg & mask_hi[i]) == (base_hi[i] & mask_hi[i]));
        cur  = kind[i];
        if (s_in != e_in) begin
          stop = 1'b1; stop_type = MT_SPLIT;
        end else if (s_in) begin
          if (!hit) begin
            hit = 1'b1; merged = cur;
          end else if (merged == MT_UC || cur == MT_UC) begin
            stop = 1'b1; stop_type = MT_UC;
          end else begin
            if ((merged == MT_WB && cur == MT_WT) || (merged == MT_WT && cur == MT_WB)) begin
              merged = MT_WT; cur = MT_WT;
            end
            if (merged != cur) begin
              stop = 1'b1; stop_type = MT_UC;
            end
          end
        end
      end
    end
  end

  always_comb begin
    if (vld == '0) assert_idle_scan_silent_R5: assert (!hit && !stop);
  end
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import mtr_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int NVAR      = 8,
  parameter bit HAS_FIXED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_start,
  input  logic [ADDR_W-1:0] q_end,
  output logic              r_valid,
  output logic [7:0]        r_type
);
  localparam int HI_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  // reset: asserted asynchronously, released on a clock edge
  logic rs_a, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs_a  <= 1'b1;
      rst_q <= rs_a;
    end
  end

  // configuration registers
  logic [7:0]        fix_q     [FIX_ENTRIES];
  logic [HI_W-1:0]   base_hi_q [NVAR];
  logic [7:0]        kind_q    [NVAR];
  logic [HI_W-1:0]   mask_hi_q [NVAR];
  logic [NVAR-1:0]   vld_q;
  logic [7:0]        dflt_q;
  logic              fen_q, ven_q, loaded_q;
  logic [ADDR_W-1:0] top_q;

  for (genvar g = 0; g < FIX_ENTRIES; g++) begin : g_fix
    logic we;
    assign we = wr_en && (wr_addr == 8'(g));
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q)  fix_q[g] <= '0;
      else if (we) fix_q[g] <= wr_data[7:0];
    end
  end

  for (genvar g = 0; g < NVAR; g++) begin : g_var
    logic we_base, we_mask;
    assign we_base = wr_en && (wr_addr == WA_VAR + 8'(2*g));
    assign we_mask = wr_en && (wr_addr == WA_VAR + 8'(2*g + 1));
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        base_hi_q[g] <= '0;
        kind_q[g]    <= '0;
        mask_hi_q[g] <= '0;
        vld_q[g]     <= 1'b0;
      end else begin
        if (we_base) begin
          base_hi_q[g] <= wr_data[ADDR_W-1:PAGE_BITS];
          kind_q[g]    <= wr_data[7:0];
        end
        if (we_mask) begin
          mask_hi_q[g] <= wr_data[ADDR_W-1:PAGE_BITS];
          vld_q[g]     <= wr_data[11];
        end
      end
    end
  end

  logic we_ctrl, we_top;
  assign we_ctrl = wr_en && (wr_addr == WA_CTRL);
  assign we_top  = wr_en && (wr_addr == WA_TOP);

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dflt_q <= '0; fen_q <= 1'b0; ven_q <= 1'b0; loaded_q <= 1'b0; top_q <= '0;
    end else begin
      if (we_ctrl) begin
        dflt_q   <= wr_data[7:0];
        fen_q    <= wr_data[10];
        ven_q    <= wr_data[11];
        loaded_q <= 1'b1;
      end
      if (we_top) top_q <= wr_data;
    end
  end

  // lookup datapath
  logic [ADDR_W-1:0]    end_incl;
  logic                 in_low;
  logic [FIX_IDX_W-1:0] fix_idx;
  logic                 stop, hit;
  logic [7:0]           stop_type, merged;

  assign end_incl = q_end - ADDR_W'(1);

  mtr_fix_index #(.HI_W(HI_W)) u_fix (
    .pg(q_start[ADDR_W-1:PAGE_BITS]), .in_low(in_low), .idx(fix_idx)
  );

  mtr_var_scan #(.HI_W(HI_W), .NVAR(NVAR)) u_scan (
    .s_pg(q_start[ADDR_W-1:PAGE_BITS]), .e_pg(end_incl[ADDR_W-1:PAGE_BITS]),
    .base_hi(base_hi_q), .kind(kind_q), .mask_hi(mask_hi_q), .vld(vld_q),
    .stop(stop), .stop_type(stop_type), .hit(hit), .merged(merged)
  );

  logic [7:0] type_d;
  logic       on;
  assign on = loaded_q && (fen_q || ven_q);

  always_comb begin
    if (!on)                                                    type_d = MT_OFF;
    else if (HAS_FIXED && in_low)                               type_d = fix_q[fix_idx];
    else if (!ven_q)                                            type_d = dflt_q;
    else if (stop)                                              type_d = stop_type;
    else if (top_q != '0 && q_start >= FOUR_G && end_incl < top_q) type_d = MT_WB;
    else if (hit)                                               type_d = merged;
    else                                                        type_d = dflt_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      r_valid <= 1'b0;
      r_type  <= MT_OFF;
    end else begin
      r_valid <= q_valid;
      if (q_valid) r_type <= type_d;
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_q)
    q_valid |=> r_valid);
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_q)
    !q_valid |=> $stable(r_type));
  assert_off_code_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (q_valid && !(loaded_q && (fen_q || ven_q))) |=> (r_type == MT_OFF));
  assert_fixed_never_split_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (q_valid && HAS_FIXED && q_start < ADDR_W'(32'h100000)) |=> (r_type != MT_SPLIT));
endmodule

// File: tb/memtype_resolver_test.sv
module memtype_resolver_test;
  localparam int AW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic          q_valid = 1'b0;
  logic [AW-1:0] q_start = '0, q_end = '0;
  logic          r_valid;
  logic [7:0]    r_type;

  int total = 0, bad = 0;

  memtype_resolver #(.ADDR_W(AW), .NVAR(8), .HAS_FIXED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_valid(q_valid), .q_start(q_start), .q_end(q_end), .r_valid(r_valid), .r_type(r_type)
  );

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  // shadow configuration, built from the write map of R11
  logic [7:0]    sh_fix [88];
  logic [AW-1:0] sh_base [8], sh_mask [8], sh_tom;
  logic [11:0]   sh_ctrl;
  logic          sh_loaded;

  function automatic logic [7:0] model(logic [AW-1:0] s, logic [AW-1:0] e);
    logic [AW-1:0] ei, m;
    logic hit, si, ein;
    logic [7:0] prev, cur;
    int k;
    ei = e - 1;
    if (!sh_loaded || sh_ctrl[11:10] == 2'b00) return 8'hFF;
    if (s < 36'h100000) begin
      if (s < 36'h80000)      k = int'(s >> 16);
      else if (s < 36'hC0000) k = 8 + int'((s - 36'h80000) >> 14);
      else                    k = 24 + int'((s - 36'hC0000) >> 12);
      return sh_fix[k];
    end
    if (!sh_ctrl[11]) return sh_ctrl[7:0];
    hit = 1'b0; prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!sh_mask[i][11]) continue;
      m = sh_mask[i] & ~36'hFFF;
      si  = ((s & m) == (sh_base[i] & m));
      ein = ((ei & m) == (sh_base[i] & m));
      if (si != ein) return 8'hFE;
      if (!si) continue;
      cur = sh_base[i][7:0];
      if (!hit) begin hit = 1'b1; prev = cur; continue; end
      if (prev == 8'h00 || cur == 8'h00) return 8'h00;
      if ((prev == 8'h06 && cur == 8'h04) || (prev == 8'h04 && cur == 8'h06)) begin
        prev = 8'h04; cur = 8'h04;
      end
      if (prev != cur) return 8'h00;
    end
    if (sh_tom != 0 && s >= 36'h1_0000_0000 && ei < sh_tom) return 8'h06;
    return hit ? prev : sh_ctrl[7:0];
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 8'd88) sh_fix[a] = d[7:0];
    else if (a >= 8'h60 && a < 8'h70) begin
      if (a[0]) sh_mask[(a - 8'h60) >> 1] = d;
      else      sh_base[(a - 8'h60) >> 1] = d;
    end else if (a == 8'h70) begin sh_ctrl = d[11:0]; sh_loaded = 1'b1; end
    else if (a == 8'h71) sh_tom = d;
  endtask

  task automatic setvar(input int i, input logic [AW-1:0] b, input logic [AW-1:0] m);
    wr(8'h60 + 8'(2*i), b);
    wr(8'h61 + 8'(2*i), m);
  endtask

  task automatic q(input logic [AW-1:0] s, input logic [AW-1:0] e, output logic [7:0] t);
    @(negedge clk);
    q_valid = 1'b1; q_start = s; q_end = e;
    @(negedge clk);
    q_valid = 1'b0;
    t = r_type;
  endtask

  task automatic qc(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] e,
                    input logic [7:0] exp);
    logic [7:0] t;
    q(s, e, t);
    chk(tag, t, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] t, hold;
    for (int i = 0; i < 88; i++) sh_fix[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin sh_base[i] = '0; sh_mask[i] = '0; end
    sh_ctrl = '0; sh_tom = '0; sh_loaded = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1 r_valid in reset", {35'd0, r_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 r_valid after reset", {35'd0, r_valid}, 0);
    chk("R1 r_type after reset", {28'd0, r_type}, 36'hFF);

    qc("R2 not loaded", 36'h4000_0000, 36'h4000_1000, 8'hFF);
    chk("R11 r_valid after query", {35'd0, r_valid}, 1);

    // fixed table: entry k holds k
    for (int i = 0; i < 88; i++) wr(8'(i), AW'(i));
    wr(8'h70, 36'hC06);
    qc("R3 first 64K", 36'h0, 36'h1000, 8'd0);
    qc("R3 last 64K", 36'h7F000, 36'h80000, 8'd7);
    qc("R3 first 16K", 36'h80000, 36'h81000, 8'd8);
    qc("R3 last 16K", 36'hBC000, 36'hBD000, 8'd23);
    qc("R3 first 4K", 36'hC0000, 36'hC1000, 8'd24);
    qc("R3 last 4K", 36'hFF000, 36'h100000, 8'd87);
    qc("R3 end ignored", 36'h45000, 36'h8000_0000, 8'd4);
    for (int p = 0; p < 256; p++)
      qc("R3 page sweep", AW'(p) << 12, (AW'(p) << 12) + 36'h1000, model(AW'(p) << 12, (AW'(p) << 12) + 36'h1000));

    wr(8'h70, 36'h006);
    qc("R2 enables clear", 36'h30000, 36'h31000, 8'hFF);
    qc("R2 enables clear high", 36'h4000_0000, 36'h4000_1000, 8'hFF);
    wr(8'h70, 36'h806);
    qc("R3 fixed with bit10 clear", 36'h30000, 36'h31000, 8'd3);
    wr(8'h70, 36'hC05);
    qc("R9 no pair valid", 36'h4000_0000, 36'h4000_1000, 8'h05);

    // pair 0: 256 MiB write-back at 0x4000_0000, junk in low 12 bits
    setvar(0, 36'h0_4000_0F06, 36'hF_F000_0FFF);
    qc("R5 R10 exact fit", 36'h4000_0000, 36'h5000_0000, 8'h06);
    qc("R6 R10 one byte over", 36'h4000_0000, 36'h5000_0001, 8'hFE);
    qc("R6 starts below", 36'h3FFF_F000, 36'h4000_1000, 8'hFE);
    qc("R9 outside pair", 36'h5000_0000, 36'h5000_1000, 8'h05);
    // pair 1: 128 MiB write-through overlapping the upper half
    setvar(1, 36'h0_4800_0004, 36'hF_F800_0800);
    qc("R7 WB+WT merge", 36'h4800_0000, 36'h4800_1000, 8'h04);
    qc("R7 WB only part", 36'h4000_0000, 36'h4000_1000, 8'h06);
    setvar(2, 36'h0_4800_0000, 36'hF_F800_0000);
    qc("R5 invalid pair ignored", 36'h4800_0000, 36'h4800_1000, 8'h04);
    wr(8'h65, 36'hF_F800_0800);
    qc("R7 uncacheable wins", 36'h4800_0000, 36'h4800_1000, 8'h00);
    wr(8'h64, 36'h0_4800_0001);
    qc("R7 other mismatch", 36'h4800_0000, 36'h4800_1000, 8'h00);
    // pair 3: 4 KiB; query spans it partially, but pair 2 stops the scan first
    setvar(3, 36'h0_4800_0006, 36'hF_FFFF_F800);
    qc("R7 order stops scan", 36'h4800_0000, 36'h4800_2000, 8'h00);
    wr(8'h65, 36'hF_F800_0000);
    qc("R6 partial after merge", 36'h4800_0000, 36'h4800_2000, 8'hFE);

    // idle hold
    hold = r_type;
    @(negedge clk);
    chk("R11 idle r_valid", {35'd0, r_valid}, 0);
    chk("R11 idle hold", {28'd0, r_type}, {28'd0, hold});

    for (int i = 0; i < 4; i++) wr(8'h61 + 8'(2*i), 36'h0);
    wr(8'h71, 36'h2_0000_0000);
    wr(8'h70, 36'hC00);
    qc("R8 above 4G", 36'h1_0000_0000, 36'h1_0000_1000, 8'h06);
    qc("R8 R10 end at bound", 36'h1_FFFF_F000, 36'h2_0000_0000, 8'h06);
    qc("R8 end past bound", 36'h1_FFFF_F000, 36'h2_0000_1000, 8'h00);
    qc("R8 start below 4G", 36'h0_FFFF_F000, 36'h1_0000_1000, 8'h00);
    setvar(0, 36'h1_0000_0004, 36'hF_F000_0800);
    qc("R8 overrides merged", 36'h1_0000_0000, 36'h1_0000_1000, 8'h06);
    setvar(0, 36'h1_0000_0004, 36'hF_FFFF_F800);
    qc("R8 split before bound", 36'h1_0000_0000, 36'h1_0000_2000, 8'hFE);
    wr(8'h70, 36'h405);
    qc("R4 variable disabled", 36'h1_0000_0000, 36'h1_0000_2000, 8'h05);

    // generated range sets compared with the model
    for (int cfg = 0; cfg < 5; cfg++) begin
      for (int i = 0; i < 8; i++) begin
        logic [AW-1:0] sz, b, m;
        logic [7:0] ty;
        int pick;
        sz = AW'(1) << (16 + ($urandom % 12));
        b  = (36'h4000_0000 | AW'($urandom & 32'h3FFF_FFFF)) & ~(sz - 1);
        m  = (~(sz - 1)) & 36'hF_FFFF_F000;
        pick = $urandom % 5;
        ty = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h01 : (pick == 2) ? 8'h04 :
             (pick == 3) ? 8'h05 : 8'h06;
        if (($urandom % 8) != 0) m = m | 36'h800;
        setvar(i, b | AW'(ty), m);
      end
      wr(8'h71, (cfg % 2 == 0) ? 36'h0 : 36'h1_8000_0000);
      wr(8'h70, AW'(12'hC00 | 12'(cfg % 7)));
      for (int n = 0; n < 300; n++) begin
        logic [AW-1:0] s, e;
        if (n % 10 == 9) s = 36'h1_0000_0000 | AW'($urandom & 32'h7FFF_F000);
        else             s = 36'h4000_0000 | AW'($urandom & 32'h3FFF_F000);
        e = s + (AW'(1) << ($urandom % 25));
        qc("R7 generated sweep", s, e, model(s, e));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule